// File: doc/BRIEF.md
# Boost Frequency Target Calculator

This block keeps a boost term, in kHz, that raises a memory-clock frequency request while traffic stays above its watermarks. A strobe for a run of readings above the upper watermark grows the term: it is multiplied by a percentage and then a fixed step is added. A strobe for a run below the lower watermark shrinks the term by a percentage, and a term that falls too low is set to zero. After each such update the block gives back two re-arm bits. Software writes these into the monitor that produced the strobes, so that one direction stops reporting once the term is pinned at full scale or at zero.

On a separate request the block computes the target frequency. The sampled average count is divided by the sampling period and scaled up by a sustain factor taken from the upper threshold. The boost term is then added. Where a dependency threshold is set and the average count reaches it, the result is raised to a floor derived from the CPU frequency. Every division uses one shared radix-2 divider, which runs for many cycles. A controller steps through the named states ST_IDLE, ST_EV_DIV, ST_EV_FIN, ST_T_AVG, ST_T_INV, ST_T_SCL and ST_T_FIN. The transitions are: ST_IDLE→ST_EV_DIV on an event strobe, ST_IDLE→ST_T_AVG on a target request, ST_EV_DIV→ST_EV_FIN on the divider result, ST_EV_FIN→ST_IDLE, ST_T_AVG→ST_T_INV, ST_T_INV→ST_T_SCL and ST_T_SCL→ST_T_FIN each on a divider result, and ST_T_FIN→ST_IDLE.

The configuration inputs (coefficients, thresholds, maximum frequency, CPU frequency) are expected to hold steady during a computation. The average count is captured when a strobe or request is accepted.

Top module: `boost_target_calc`

## Requirements
- R1: After reset, boost is 0, arm_above and arm_below are both 1, target is 0 and done is 0.
- R2: On an upper event the new boost is floor(old × up_coeff / 100) + 16000. If that sum is at or above max_freq, boost becomes max_freq and arm_above becomes 0. Otherwise boost becomes the sum and arm_above becomes 1. arm_below becomes 1 in both cases.
- R3: On a lower event let q = floor(old × dn_coeff / 100). If q < 8000, boost becomes 0 and arm_below becomes 0. Otherwise boost becomes q and arm_below becomes 1. arm_above becomes 1 in both cases.
- R4: After the R2/R3 update, if dep_thresh is nonzero: arm_below is forced to 1 when the captured average is at or above dep_thresh; otherwise, if the new boost is 0, arm_below is forced to 0.
- R5: A target request yields target = floor(floor(floor(avg/12) × floor(10000/up_thresh)) / 100) + boost. A result above 2^FW−1 saturates.
- R6: If dep_thresh is nonzero and avg ≥ dep_thresh, target becomes the larger of the R5 value and a CPU-derived floor. The floor is chosen by the highest matching CPU threshold: ≥1400000 → max_freq, ≥1200000 → 750000, ≥1100000 → 600000, ≥1000000 → 500000, ≥800000 → 375000, ≥500000 → 200000, ≥250000 → 100000, and 0 below 250000. Each nonzero entry is limited to max_freq.
- R7: An upper and a lower strobe in the same cycle act as an upper event. A strobe together with a target request starts only the event, and the request is dropped, so target is unchanged.
- R8: Strobes and requests that arrive while a computation is in progress are ignored.
- R9: Each accepted strobe or request ends with done high for exactly one cycle. The updated outputs are visible in that same cycle, and boost and target change at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_up | input | 1 | Strobe: run of readings above the upper watermark |
| evt_dn | input | 1 | Strobe: run of readings below the lower watermark |
| calc_req | input | 1 | Strobe: compute a new target |
| avg_cnt | input | FW | Sampled average activity count |
| max_freq | input | FW | Highest allowed frequency, kHz |
| up_coeff | input | CW | Growth percentage for upper events |
| dn_coeff | input | CW | Decay percentage for lower events |
| up_thresh | input | CW | Upper watermark percentage, sets the sustain factor |
| dep_thresh | input | FW | Average count that enables the CPU floor; 0 disables it |
| cpu_freq | input | FW | Current CPU frequency, kHz |
| boost | output | FW | Boost term, kHz |
| arm_above | output | 1 | Re-arm bit for the above-watermark run detector |
| arm_below | output | 1 | Re-arm bit for the below-watermark run detector |
| target | output | FW | Computed target frequency, kHz |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest states to reach are the two where a re-arm bit drops. arm_above falls only when repeated growth drives the sum past the maximum, and arm_below falls only when repeated decay pushes the term under half a step while the dependency override is inactive. The stimulus reaches both by running a fixed pattern of growth strobes followed by decay strobes. This pattern is swept over several coefficient sets, a small and a large maximum, and dependency thresholds both zero and set. Averages are spread on both sides of the dependency threshold, and a target request follows each strobe. The CPU floor is then swept across every lookup boundary, at the boundary and one below it, under both a clamping and a non-clamping maximum.

// File: rtl/boost_calc_pkg.sv
package boost_calc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EV_DIV,
        ST_EV_FIN,
        ST_T_AVG,
        ST_T_INV,
        ST_T_SCL,
        ST_T_FIN
    } calc_state_e;

    // CPU-to-memory floor map, highest CPU threshold first.
    localparam int unsigned MAP_N = 7;
    localparam logic [31:0] MAP_CPU [MAP_N] = '{
        32'd1400000, 32'd1200000, 32'd1100000, 32'd1000000,
        32'd800000,  32'd500000,  32'd250000
    };
    localparam logic [31:0] MAP_MEM [MAP_N] = '{
        32'd0,       32'd750000,  32'd600000,  32'd500000,
        32'd375000,  32'd200000,  32'd100000
    };
    // Bit i set: entry i means "full scale" (the maximum frequency).
    localparam logic [MAP_N-1:0] MAP_FULL = 7'b0000001;

endpackage

// File: rtl/seq_divider.sv
module seq_divider #(
    parameter int DW = 48
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] num,
    input  logic [DW-1:0] den,
    output logic [DW-1:0] quo,
    output logic          valid
);
    localparam int CNTW = $clog2(DW + 1);

    logic [DW-1:0]   quo_q;
    logic [DW-1:0]   rem_q;
    logic [DW-1:0]   den_q;
    logic [CNTW-1:0] cnt_q;
    logic            run_q;
    logic            valid_q;

    logic [DW:0] rem_sh;
    logic [DW:0] diff;
    logic        fits;

    // Borrow bit of the trial subtraction decides the quotient bit.
    assign rem_sh = {rem_q, quo_q[DW-1]};
    assign diff   = rem_sh - {1'b0, den_q};
    assign fits   = ~diff[DW];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quo_q   <= '0;
            rem_q   <= '0;
            den_q   <= '0;
            cnt_q   <= '0;
            run_q   <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (start) begin
                quo_q <= num;
                rem_q <= '0;
                den_q <= den;
                cnt_q <= CNTW'(DW);
                run_q <= 1'b1;
            end else if (run_q) begin
                rem_q <= fits ? diff[DW-1:0] : rem_sh[DW-1:0];
                quo_q <= {quo_q[DW-2:0], fits};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNTW'(1)) begin
                    run_q   <= 1'b0;
                    valid_q <= 1'b1;
                end
            end
        end
    end

    assign quo   = quo_q;
    assign valid = valid_q;

endmodule

// File: rtl/cpu_mem_map.sv
module cpu_mem_map
    import boost_calc_pkg::*;
#(
    parameter int FW = 32
) (
    input  logic [FW-1:0] cpu_freq,
    input  logic [FW-1:0] max_freq,
    output logic [FW-1:0] mem_floor
);
    logic [MAP_N-1:0] hit;
    logic [FW-1:0]    ent_val [MAP_N];

    for (genvar i = 0; i < MAP_N; i++) begin : g_ent
        logic [FW-1:0] raw;
        assign raw = FW'(MAP_MEM[i]);
        assign hit[i] = (cpu_freq >= FW'(MAP_CPU[i]));
        if (MAP_FULL[i]) begin : g_full
            assign ent_val[i] = max_freq;
        end else begin : g_lim
            assign ent_val[i] = (raw >= max_freq) ? max_freq : raw;
        end
    end

    // Lowest entry first, so the highest matching threshold wins.
    always_comb begin
        mem_floor = '0;
        for (int i = MAP_N - 1; i >= 0; i--) begin
            if (hit[i]) mem_floor = ent_val[i];
        end
    end

endmodule

// File: rtl/boost_target_calc.sv
module boost_target_calc
    import boost_calc_pkg::*;
#(
    parameter int FW      = 32,
    parameter int CW      = 12,
    parameter int SW      = 16,
    parameter int PERIOD  = 12,
    parameter int STEP    = 16000,
    parameter int PCT     = 100,
    parameter int SUSTAIN = 10000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt_up,
    input  logic          evt_dn,
    input  logic          calc_req,
    input  logic [FW-1:0] avg_cnt,
    input  logic [FW-1:0] max_freq,
    input  logic [CW-1:0] up_coeff,
    input  logic [CW-1:0] dn_coeff,
    input  logic [CW-1:0] up_thresh,
    input  logic [FW-1:0] dep_thresh,
    input  logic [FW-1:0] cpu_freq,
    output logic [FW-1:0] boost,
    output logic          arm_above,
    output logic          arm_below,
    output logic [FW-1:0] target,
    output logic          done
);
    localparam int DW   = FW + SW;
    localparam int HALF = STEP / 2;

    calc_state_e state_q, state_d;

    logic [FW-1:0] boost_q, target_q, avg_q;
    logic          above_q, below_q, done_q, op_up_q;
    logic [DW-1:0] q1_q;

    logic          div_start;
    logic [DW-1:0] div_num, div_den, div_quo;
    logic          div_valid;
    logic [FW-1:0] map_floor;

    logic          any_evt, dep_on, dep_hit;
    logic [DW-1:0] up_sum, t_sum;
    logic [FW-1:0] nb_val, t_val;
    logic          na_val, nbl_val;

    assign any_evt = evt_up | evt_dn;
    assign dep_on  = (dep_thresh != '0);
    assign dep_hit = dep_on && (avg_q >= dep_thresh);

    seq_divider #(.DW(DW)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_start),
        .num   (div_num),
        .den   (div_den),
        .quo   (div_quo),
        .valid (div_valid)
    );

    cpu_mem_map #(.FW(FW)) u_map (
        .cpu_freq  (cpu_freq),
        .max_freq  (max_freq),
        .mem_floor (map_floor)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and divider launch
    always_comb begin
        state_d   = state_q;
        div_start = 1'b0;
        div_num   = '0;
        div_den   = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (any_evt) begin
                    div_start = 1'b1;
                    div_num   = DW'(boost_q) * DW'(evt_up ? up_coeff : dn_coeff);
                    div_den   = DW'(PCT);
                    state_d   = ST_EV_DIV;
                end else if (calc_req) begin
                    div_start = 1'b1;
                    div_num   = DW'(avg_cnt);
                    div_den   = DW'(PERIOD);
                    state_d   = ST_T_AVG;
                end
            end
            ST_EV_DIV: if (div_valid) state_d = ST_EV_FIN;
            ST_EV_FIN: state_d = ST_IDLE;
            ST_T_AVG: begin
                if (div_valid) begin
                    div_start = 1'b1;
                    div_num   = DW'(SUSTAIN);
                    div_den   = DW'(up_thresh);
                    state_d   = ST_T_INV;
                end
            end
            ST_T_INV: begin
                if (div_valid) begin
                    div_start = 1'b1;
                    div_num   = q1_q * div_quo;
                    div_den   = DW'(PCT);
                    state_d   = ST_T_SCL;
                end
            end
            ST_T_SCL: if (div_valid) state_d = ST_T_FIN;
            ST_T_FIN: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Boost update and re-arm decisions
    always_comb begin
        up_sum  = div_quo + DW'(STEP);
        nb_val  = boost_q;
        na_val  = above_q;
        nbl_val = below_q;
        if (op_up_q) begin
            nbl_val = 1'b1;
            if (up_sum >= DW'(max_freq)) begin
                nb_val = max_freq;
                na_val = 1'b0;
            end else begin
                nb_val = up_sum[FW-1:0];
                na_val = 1'b1;
            end
        end else begin
            na_val = 1'b1;
            if (div_quo < DW'(HALF)) begin
                nb_val  = '0;
                nbl_val = 1'b0;
            end else begin
                nb_val  = div_quo[FW-1:0];
                nbl_val = 1'b1;
            end
        end
        if (dep_on) begin
            if (avg_q >= dep_thresh) nbl_val = 1'b1;
            else if (nb_val == '0)   nbl_val = 1'b0;
        end
    end

    // Target assembly with CPU floor and saturation
    always_comb begin
        t_sum = div_quo + DW'(boost_q);
        if (dep_hit && (DW'(map_floor) > t_sum)) t_sum = DW'(map_floor);
        t_val = (|t_sum[DW-1:FW]) ? '1 : t_sum[FW-1:0];
    end

    // Outputs and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            boost_q  <= '0;
            above_q  <= 1'b1;
            below_q  <= 1'b1;
            target_q <= '0;
            done_q   <= 1'b0;
            op_up_q  <= 1'b0;
            avg_q    <= '0;
            q1_q     <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (any_evt) begin
                        op_up_q <= evt_up;
                        avg_q   <= avg_cnt;
                    end else if (calc_req) begin
                        avg_q   <= avg_cnt;
                    end
                end
                ST_EV_FIN: begin
                    boost_q <= nb_val;
                    above_q <= na_val;
                    below_q <= nbl_val;
                    done_q  <= 1'b1;
                end
                ST_T_AVG: if (div_valid) q1_q <= div_quo;
                ST_T_FIN: begin
                    target_q <= t_val;
                    done_q   <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign boost     = boost_q;
    assign arm_above = above_q;
    assign arm_below = below_q;
    assign target    = target_q;
    assign done      = done_q;

endmodule

// File: rtl/boost_calc_chk.sv
module boost_calc_chk #(
    parameter int FW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [FW-1:0] boost,
    input logic [FW-1:0] max_freq,
    input logic          arm_above,
    input logic          arm_below,
    input logic [FW-1:0] target,
    input logic          done
);
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_boost_at_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(boost) |-> done);

    p_target_at_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(target) |-> done);

    p_above_clamp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(arm_above) |-> (boost == max_freq));

    p_below_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(arm_below) |-> (boost == '0));

endmodule

bind boost_target_calc boost_calc_chk #(.FW(FW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .boost     (boost),
    .max_freq  (max_freq),
    .arm_above (arm_above),
    .arm_below (arm_below),
    .target    (target),
    .done      (done)
);

// File: tb/sim_boost_target_calc.sv
module sim_boost_target_calc;
    localparam int CLK_PERIOD = 10;
    localparam int FW = 32;
    localparam int CW = 12;
    localparam int WD_CYCLES = 190000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          evt_up = 1'b0, evt_dn = 1'b0, calc_req = 1'b0;
    logic [FW-1:0] avg_cnt = '0, max_freq = '0, dep_thresh = '0, cpu_freq = '0;
    logic [CW-1:0] up_coeff = '0, dn_coeff = '0, up_thresh = 12'd60;
    logic [FW-1:0] boost, target;
    logic          arm_above, arm_below, done;

    int checks = 0;
    int fails  = 0;
    int done_cnt = 0;

    longint unsigned m_boost;
    bit              m_above, m_below;
    longint unsigned m_target;

    always #(CLK_PERIOD/2) clk = ~clk;

    boost_target_calc u0 (
        .clk(clk), .rst_n(rst_n), .evt_up(evt_up), .evt_dn(evt_dn),
        .calc_req(calc_req), .avg_cnt(avg_cnt), .max_freq(max_freq),
        .up_coeff(up_coeff), .dn_coeff(dn_coeff), .up_thresh(up_thresh),
        .dep_thresh(dep_thresh), .cpu_freq(cpu_freq), .boost(boost),
        .arm_above(arm_above), .arm_below(arm_below), .target(target),
        .done(done)
    );

    always @(posedge clk) if (done) done_cnt++;

    task automatic chk(input bit ok, input string tag,
                       input longint unsigned act, input longint unsigned exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint unsigned map_floor(longint unsigned cpu,
                                                   longint unsigned mx);
        longint unsigned v;
        if      (cpu >= 1400000) return mx;
        else if (cpu >= 1200000) v = 750000;
        else if (cpu >= 1100000) v = 600000;
        else if (cpu >= 1000000) v = 500000;
        else if (cpu >= 800000)  v = 375000;
        else if (cpu >= 500000)  v = 200000;
        else if (cpu >= 250000)  v = 100000;
        else return 0;
        return (v >= mx) ? mx : v;
    endfunction

    function automatic longint unsigned exp_target(longint unsigned avg);
        longint unsigned t;
        t = ((avg / 12) * (10000 / longint'(up_thresh))) / 100 + m_boost;
        if (dep_thresh != 0 && avg >= dep_thresh)
            if (map_floor(cpu_freq, max_freq) > t) t = map_floor(cpu_freq, max_freq);
        if (t > 64'hFFFF_FFFF) t = 64'hFFFF_FFFF;
        return t;
    endfunction

    task automatic model_event(input bit up, input longint unsigned avg);
        longint unsigned q;
        if (up) begin
            q = m_boost * up_coeff / 100 + 16000;
            m_below = 1;
            if (q >= max_freq) begin m_boost = max_freq; m_above = 0; end
            else begin m_boost = q; m_above = 1; end
        end else begin
            q = m_boost * dn_coeff / 100;
            m_above = 1;
            if (q < 8000) begin m_boost = 0; m_below = 0; end
            else begin m_boost = q; m_below = 1; end
        end
        if (dep_thresh != 0) begin
            if (avg >= dep_thresh) m_below = 1;
            else if (m_boost == 0) m_below = 0;
        end
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!done && n < 1000) begin @(negedge clk); n++; end
        chk(done == 1'b1, {tag, " done timeout"}, done, 1);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_boost = 0; m_above = 1; m_below = 1; m_target = 0;
        @(negedge clk);
    endtask

    task automatic run_event(input bit up, input bit dn, input longint unsigned avg,
                             input string tag);
        @(negedge clk); evt_up = up; evt_dn = dn; avg_cnt = FW'(avg);
        @(negedge clk); evt_up = 0; evt_dn = 0;
        wait_done(tag);
        model_event(up, avg);
        chk(boost == m_boost, {tag, " boost"}, boost, m_boost);
        chk(arm_above == m_above, {tag, " arm_above"}, arm_above, m_above);
        chk(arm_below == m_below, {tag, " arm_below"}, arm_below, m_below);
        @(negedge clk);
        chk(done == 1'b0, "R9 done width", done, 0);
    endtask

    task automatic run_calc(input longint unsigned avg, input string tag);
        @(negedge clk); calc_req = 1; avg_cnt = FW'(avg);
        @(negedge clk); calc_req = 0;
        wait_done(tag);
        m_target = exp_target(avg);
        chk(target == m_target, {tag, " target"}, target, m_target);
        @(negedge clk);
        chk(done == 1'b0, "R9 done width", done, 0);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", WD_CYCLES, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        int ups   [3] = '{200, 800, 150};
        int dns   [3] = '{50, 90, 75};
        int uts   [3] = '{60, 27, 40};
        int mxs   [2] = '{100000, 30000};
        int deps  [2] = '{0, 50000};
        int cpus  [8] = '{0, 300000, 900000, 1250000, 1500000, 1000000, 600000, 1100000};
        int bnds  [7] = '{1400000, 1200000, 1100000, 1000000, 800000, 500000, 250000};
        int snap;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(boost == 0, "R1 boost", boost, 0);
        chk(arm_above == 1, "R1 arm_above", arm_above, 1);
        chk(arm_below == 1, "R1 arm_below", arm_below, 1);
        chk(target == 0, "R1 target", target, 0);
        chk(done == 0, "R1 done", done, 0);
        rst_n = 1'b1;

        // R2 R3 R4 R5 R6: sweep of coefficients, maxima, dependency thresholds
        for (int c = 0; c < 3; c++) begin
            for (int m = 0; m < 2; m++) begin
                for (int d = 0; d < 2; d++) begin
                    up_coeff = CW'(ups[c]); dn_coeff = CW'(dns[c]);
                    up_thresh = CW'(uts[c]); max_freq = FW'(mxs[m]);
                    dep_thresh = FW'(deps[d]);
                    do_reset();
                    for (int k = 0; k < 12; k++) begin
                        longint unsigned avg = (longint'(k) * 17011 + 3000) % 90000;
                        bit up = (k < 5) || (k == 8);
                        cpu_freq = FW'(cpus[k % 8]);
                        run_event(up, !up, avg, up ? "R2/R4 upper" : "R3/R4 lower");
                        run_calc((avg * 3 + 1234) % 120000, "R5/R6 sweep");
                    end
                end
            end
        end

        // R6: every lookup boundary and one below it, clamped and unclamped maxima
        up_coeff = 200; dn_coeff = 50; up_thresh = 60;
        for (int m = 0; m < 2; m++) begin
            max_freq = (m == 0) ? 400000 : 2000000;
            dep_thresh = 1000;
            do_reset();
            for (int b = 0; b < 7; b++) begin
                cpu_freq = FW'(bnds[b]);     run_calc(24000, "R6 boundary");
                cpu_freq = FW'(bnds[b] - 1); run_calc(24000, "R6 below boundary");
            end
            cpu_freq = 3000000; run_calc(24000, "R6 top");
            run_calc(500, "R6 avg under dep");
        end
        dep_thresh = 0; cpu_freq = 3000000;
        run_calc(24000, "R6 dep zero");

        // R7: both strobes act as upper
        max_freq = 100000; dep_thresh = 0;
        do_reset();
        run_event(1, 1, 100, "R7 both strobes");

        // R7: strobe plus request: event only, target unchanged
        run_calc(36000, "R7 prep");
        snap = done_cnt;
        @(negedge clk); evt_dn = 1; calc_req = 1; avg_cnt = 777;
        @(negedge clk); evt_dn = 0; calc_req = 0;
        wait_done("R7 event wins");
        model_event(0, 777);
        chk(boost == m_boost, "R7 boost", boost, m_boost);
        chk(target == m_target, "R7 target unchanged", target, m_target);
        repeat (200) @(negedge clk);
        chk(done_cnt == snap + 1, "R7 single completion", done_cnt - snap, 1);

        // R8: strobe during a target computation is ignored
        snap = done_cnt;
        @(negedge clk); calc_req = 1; avg_cnt = 48000;
        @(negedge clk); calc_req = 0;
        repeat (3) @(negedge clk);
        evt_up = 1;
        @(negedge clk); evt_up = 0;
        wait_done("R8 busy");
        m_target = exp_target(48000);
        chk(target == m_target, "R8 target", target, m_target);
        chk(boost == m_boost, "R8 boost untouched", boost, m_boost);
        repeat (200) @(negedge clk);
        chk(done_cnt == snap + 1, "R8 no extra completion", done_cnt - snap, 1);
        chk(boost == m_boost, "R8 boost still untouched", boost, m_boost);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule